// File: doc/BRIEF.md
# Direct-Mapped Instruction Fetch Cache with Tail Fill

This block sits between a processor's instruction fetch port and a word-addressed backing memory. It keeps 256 lines of four 32-bit words each, looked up directly by address. A fetch that hits is answered from the stored line on the next cycle. A fetch that misses reads memory from the requested word up to the last word of the line. The line then records the full fetch address as its tag, so any word below that point still counts as a miss later.

Addresses at or above 0xA0000000 are never cached. They are read once from memory and the answer is passed through. Clearing the enable input sends every fetch down the same uncached path. A one-cycle invalidate pulse empties the whole cache; the system raises it when the cache is isolated from memory. When memory reports that an address has no backing storage, the fetch returns zero and the line is left as it was.

The requester issues one fetch at a time. A new request is taken only in a cycle where no memory request is pending, and that includes the cycle in which the previous result is valid.

Top module: `icache_pfill`

## Requirements
- R1: The line index is fetch address bits [11:4] (256 lines) and the word select is bits [3:2]. Two addresses that differ only above bit 11 share a line and evict each other.
- R2: Only addresses below 0xA0000000 are cached. Any other fetch makes exactly one memory read at the word-aligned address, returns that word, and changes no line.
- R3: A fetch hits only if bits [31:4] of the stored tag equal bits [31:4] of the fetch address and the fetch address is not below the full stored tag.
- R4: On a hit, fetch_valid_o is high in the cycle after the request with the stored word, and no memory request is made.
- R5: On a miss, memory is read at ascending word addresses from the requested word through word 3 of the line. The tag becomes the full 32-bit fetch address, and words below the requested one are not written.
- R6: On a miss, fetch_valid_o rises in the cycle after the last fill word is accepted and carries the requested word.
- R7: Reset and a one-cycle inval_i pulse set every tag and word to all ones, so the next cacheable fetch to any line misses.
- R8: A memory response with mem_none_i high ends the fetch with fetch_data_o = 0 in the next cycle. The line keeps its previous tag and data.
- R9: While en_i is low, every fetch takes the uncached path of R2, and the cache contents are unchanged.
- R10: mem_req_o stays high with a stable mem_addr_o until a cycle with mem_valid_i high accepts the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Cache enable; low forces uncached fetches |
| inval_i | input | 1 | Pulse that clears every line |
| fetch_req_i | input | 1 | Fetch request, taken while no memory request is pending |
| fetch_addr_i | input | 32 | Fetch byte address |
| fetch_data_o | output | 32 | Fetched instruction word |
| fetch_valid_o | output | 1 | One-cycle strobe marking fetch_data_o valid |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Word-aligned memory read address |
| mem_valid_i | input | 1 | Memory response valid; accepts the current request |
| mem_data_i | input | 32 | Memory read data |
| mem_none_i | input | 1 | Response flag: no backing storage at this address |

## Verification
A wrong tag shows up at the ports as a surplus or missing memory read on the very next fetch to that line. A hit that should miss reads zero words and returns stale data one cycle after the request. A miss that should hit raises mem_req_o in the cycle after the request. A fill that starts at the wrong word shows up as the wrong count of reads or the wrong first address within the same fetch. Stale data is made visible by changing the memory contents between the filling fetch and a later hit.

// File: rtl/icpf_pkg.sv
package icpf_pkg;
  localparam int unsigned LINES_DEF = 256;
  localparam int unsigned WORDS_DEF = 4;
  localparam int unsigned AW_DEF    = 32;
  localparam int unsigned DW_DEF    = 32;
  localparam logic [31:0] UNC_BASE_DEF = 32'hA000_0000;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FILL   = 2'd1,
    ST_BYPASS = 2'd2
  } icpf_state_e;
endpackage

// File: rtl/icpf_store.sv
module icpf_store #(
  parameter int unsigned LINES = icpf_pkg::LINES_DEF,
  parameter int unsigned WORDS = icpf_pkg::WORDS_DEF,
  parameter int unsigned AW    = icpf_pkg::AW_DEF,
  parameter int unsigned DW    = icpf_pkg::DW_DEF,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       inval_i,
  input  logic [IDX_W-1:0]           rd_idx_i,
  output logic [AW-1:0]              rd_tag_o,
  output logic [WORDS-1:0][DW-1:0]   rd_line_o,
  input  logic                       wr_en_i,
  input  logic [IDX_W-1:0]           wr_idx_i,
  input  logic [AW-1:0]              wr_tag_i,
  input  logic [WORDS-1:0]           wr_mask_i,
  input  logic [WORDS-1:0][DW-1:0]   wr_line_i
);
  logic [AW-1:0] tag_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) tag_q[i] <= '1;
    end else if (inval_i) begin
      for (int i = 0; i < LINES; i++) tag_q[i] <= '1;
    end else if (wr_en_i) begin
      tag_q[wr_idx_i] <= wr_tag_i;
    end
  end

  assign rd_tag_o = tag_q[rd_idx_i];

  // one storage lane per word slot so a fill writes only its tail
  for (genvar w = 0; w < WORDS; w++) begin : g_lane
    logic [DW-1:0] word_q [LINES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < LINES; i++) word_q[i] <= '1;
      end else if (inval_i) begin
        for (int i = 0; i < LINES; i++) word_q[i] <= '1;
      end else if (wr_en_i && wr_mask_i[w]) begin
        word_q[wr_idx_i] <= wr_line_i[w];
      end
    end

    assign rd_line_o[w] = word_q[rd_idx_i];
  end
endmodule

// File: rtl/icpf_lookup.sv
module icpf_lookup #(
  parameter int unsigned WORDS = icpf_pkg::WORDS_DEF,
  parameter int unsigned AW    = icpf_pkg::AW_DEF,
  parameter int unsigned DW    = icpf_pkg::DW_DEF,
  parameter logic [AW-1:0] UNC_BASE = AW'(icpf_pkg::UNC_BASE_DEF),
  localparam int unsigned WSEL_W = $clog2(WORDS),
  localparam int unsigned OFF_W  = WSEL_W + 2
) (
  input  logic                     en_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [AW-1:0]            tag_i,
  input  logic [WORDS-1:0][DW-1:0] line_i,
  output logic                     cacheable_o,
  output logic                     hit_o,
  output logic [DW-1:0]            word_o
);
  logic line_match;

  assign cacheable_o = en_i && (addr_i < UNC_BASE);
  assign line_match  = (tag_i[AW-1:OFF_W] == addr_i[AW-1:OFF_W]);
  // a tail-filled line only covers words at or above its tag
  assign hit_o  = cacheable_o && line_match && (addr_i >= tag_i);
  assign word_o = line_i[addr_i[OFF_W-1:2]];
endmodule

// File: rtl/icpf_ctrl.sv
module icpf_ctrl #(
  parameter int unsigned LINES = icpf_pkg::LINES_DEF,
  parameter int unsigned WORDS = icpf_pkg::WORDS_DEF,
  parameter int unsigned AW    = icpf_pkg::AW_DEF,
  parameter int unsigned DW    = icpf_pkg::DW_DEF,
  localparam int unsigned IDX_W  = $clog2(LINES),
  localparam int unsigned WSEL_W = $clog2(WORDS),
  localparam int unsigned OFF_W  = WSEL_W + 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     fetch_req_i,
  input  logic [AW-1:0]            fetch_addr_i,
  input  logic                     cacheable_i,
  input  logic                     hit_i,
  input  logic [DW-1:0]            hit_word_i,
  output logic [DW-1:0]            fetch_data_o,
  output logic                     fetch_valid_o,
  output logic                     mem_req_o,
  output logic [AW-1:0]            mem_addr_o,
  input  logic                     mem_valid_i,
  input  logic [DW-1:0]            mem_data_i,
  input  logic                     mem_none_i,
  output logic                     wr_en_o,
  output logic [IDX_W-1:0]         wr_idx_o,
  output logic [AW-1:0]            wr_tag_o,
  output logic [WORDS-1:0]         wr_mask_o,
  output logic [WORDS-1:0][DW-1:0] wr_line_o
);
  import icpf_pkg::*;

  icpf_state_e             state_q;
  logic [AW-1:0]           addr_q;
  logic [WSEL_W-1:0]       ptr_q;
  logic [WORDS-1:0][DW-1:0] buf_q;
  logic [DW-1:0]           rdata_q;
  logic                    rvalid_q;
  logic                    take;
  logic                    last_word;
  logic [WSEL_W-1:0]       start_w;

  assign take      = mem_valid_i && (state_q != ST_IDLE);
  assign last_word = (ptr_q == WSEL_W'(WORDS - 1));
  assign start_w   = addr_q[OFF_W-1:2];

  assign mem_req_o  = (state_q != ST_IDLE);
  assign mem_addr_o = (state_q == ST_FILL) ? {addr_q[AW-1:OFF_W], ptr_q, 2'b00}
                                           : {addr_q[AW-1:2], 2'b00};

  assign wr_en_o  = (state_q == ST_FILL) && mem_valid_i && !mem_none_i && last_word;
  assign wr_idx_o = addr_q[OFF_W+IDX_W-1:OFF_W];
  assign wr_tag_o = addr_q;

  for (genvar w = 0; w < WORDS; w++) begin : g_wr
    assign wr_mask_o[w] = (WSEL_W'(w) >= start_w);
    assign wr_line_o[w] = (WSEL_W'(w) == ptr_q) ? mem_data_i : buf_q[w];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      ptr_q    <= '0;
      buf_q    <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (fetch_req_i) begin
            if (hit_i) begin
              rdata_q  <= hit_word_i;
              rvalid_q <= 1'b1;
            end else begin
              addr_q  <= fetch_addr_i;
              ptr_q   <= fetch_addr_i[OFF_W-1:2];
              state_q <= cacheable_i ? ST_FILL : ST_BYPASS;
            end
          end
        end
        ST_FILL: begin
          if (take) begin
            if (mem_none_i) begin
              rdata_q  <= '0;
              rvalid_q <= 1'b1;
              state_q  <= ST_IDLE;
            end else begin
              buf_q[ptr_q] <= mem_data_i;
              // first word of the fill is the requested one
              if (ptr_q == start_w) rdata_q <= mem_data_i;
              if (last_word) begin
                rvalid_q <= 1'b1;
                state_q  <= ST_IDLE;
              end else begin
                ptr_q <= ptr_q + 1'b1;
              end
            end
          end
        end
        ST_BYPASS: begin
          if (take) begin
            rdata_q  <= mem_none_i ? '0 : mem_data_i;
            rvalid_q <= 1'b1;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign fetch_data_o  = rdata_q;
  assign fetch_valid_o = rvalid_q;
endmodule

// File: rtl/icache_pfill.sv
module icache_pfill #(
  parameter int unsigned LINES = icpf_pkg::LINES_DEF,
  parameter int unsigned WORDS = icpf_pkg::WORDS_DEF,
  parameter int unsigned AW    = icpf_pkg::AW_DEF,
  parameter int unsigned DW    = icpf_pkg::DW_DEF,
  parameter logic [AW-1:0] UNC_BASE = AW'(icpf_pkg::UNC_BASE_DEF),
  localparam int unsigned IDX_W  = $clog2(LINES),
  localparam int unsigned WSEL_W = $clog2(WORDS),
  localparam int unsigned OFF_W  = WSEL_W + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          inval_i,
  input  logic          fetch_req_i,
  input  logic [AW-1:0] fetch_addr_i,
  output logic [DW-1:0] fetch_data_o,
  output logic          fetch_valid_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_valid_i,
  input  logic [DW-1:0] mem_data_i,
  input  logic          mem_none_i
);
  logic [AW-1:0]            rd_tag;
  logic [WORDS-1:0][DW-1:0] rd_line;
  logic                     lookup_cacheable;
  logic                     lookup_hit;
  logic [DW-1:0]            hit_word;
  logic                     commit_en;
  logic [IDX_W-1:0]         wr_idx;
  logic [AW-1:0]            wr_tag;
  logic [WORDS-1:0]         wr_mask;
  logic [WORDS-1:0][DW-1:0] wr_line;

  icpf_store #(.LINES(LINES), .WORDS(WORDS), .AW(AW), .DW(DW)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inval_i   (inval_i),
    .rd_idx_i  (fetch_addr_i[OFF_W+IDX_W-1:OFF_W]),
    .rd_tag_o  (rd_tag),
    .rd_line_o (rd_line),
    .wr_en_i   (commit_en),
    .wr_idx_i  (wr_idx),
    .wr_tag_i  (wr_tag),
    .wr_mask_i (wr_mask),
    .wr_line_i (wr_line)
  );

  icpf_lookup #(.WORDS(WORDS), .AW(AW), .DW(DW), .UNC_BASE(UNC_BASE)) u_lookup (
    .en_i        (en_i),
    .addr_i      (fetch_addr_i),
    .tag_i       (rd_tag),
    .line_i      (rd_line),
    .cacheable_o (lookup_cacheable),
    .hit_o       (lookup_hit),
    .word_o      (hit_word)
  );

  icpf_ctrl #(.LINES(LINES), .WORDS(WORDS), .AW(AW), .DW(DW)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fetch_req_i   (fetch_req_i),
    .fetch_addr_i  (fetch_addr_i),
    .cacheable_i   (lookup_cacheable),
    .hit_i         (lookup_hit),
    .hit_word_i    (hit_word),
    .fetch_data_o  (fetch_data_o),
    .fetch_valid_o (fetch_valid_o),
    .mem_req_o     (mem_req_o),
    .mem_addr_o    (mem_addr_o),
    .mem_valid_i   (mem_valid_i),
    .mem_data_i    (mem_data_i),
    .mem_none_i    (mem_none_i),
    .wr_en_o       (commit_en),
    .wr_idx_o      (wr_idx),
    .wr_tag_o      (wr_tag),
    .wr_mask_o     (wr_mask),
    .wr_line_o     (wr_line)
  );
endmodule

// File: rtl/icpf_checker.sv
module icpf_checker #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter logic [AW-1:0] UNC_BASE = 32'hA000_0000
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          fetch_req_i,
  input logic [DW-1:0] fetch_data_o,
  input logic          fetch_valid_o,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_valid_i,
  input logic          mem_none_i,
  input logic          lookup_hit,
  input logic          commit_en
);
  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_req_o && fetch_req_i && lookup_hit) |=> (fetch_valid_o && !mem_req_o)); // R4

  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o))); // R10

  AST_NONE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_valid_i && mem_none_i) |=> (fetch_valid_o && fetch_data_o == '0)); // R8

  AST_COMMIT_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_en |-> (mem_addr_o < UNC_BASE && mem_addr_o[3:2] == 2'b11)); // R5

  AST_COMMIT_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_en |=> (fetch_valid_o && !mem_req_o)); // R6

  AST_DISABLED_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && fetch_req_i) |-> !lookup_hit); // R9
endmodule

bind icache_pfill icpf_checker u_chk (.*);

// File: tb/icache_pfill_bench.sv
`timescale 1ns/1ps
module icache_pfill_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b1;
  logic        inval_i = 1'b0;
  logic        fetch_req_i = 1'b0;
  logic [31:0] fetch_addr_i = '0;
  logic [31:0] fetch_data_o;
  logic        fetch_valid_o;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_valid_i = 1'b0;
  logic [31:0] mem_data_i = '0;
  logic        mem_none_i = 1'b0;

  int errors = 0;
  int checks = 0;
  int rd_cnt = 0;
  int hs_err = 0;
  int lat = 2;
  int gen = 0;
  int cyc_cnt = 0;
  int last_resp_cyc = 0;
  int wait_cnt = 0;
  logic [31:0] held_addr = '0;
  logic [31:0] rd_log [8];
  bit done = 0;

  always #10 clk_i = ~clk_i;

  icache_pfill u_icache_pfill (.*);

  always @(posedge clk_i) cyc_cnt <= cyc_cnt + 1;

  function automatic logic [31:0] mem_word(input logic [31:0] a, input int g);
    return a ^ 32'h5A00_00A5 ^ (g != 0 ? 32'h0101_0000 : 32'h0);
  endfunction

  function automatic bit no_store(input logic [31:0] a);
    return (a[31:24] == 8'h1F) || (a[31:24] == 8'hBF);
  endfunction

  // memory model: answers after lat cycles, one word per request
  always @(negedge clk_i) begin
    if (mem_valid_i) begin
      mem_valid_i = 1'b0;
      mem_none_i  = 1'b0;
      wait_cnt    = 0;
    end else if (mem_req_o) begin
      if (wait_cnt == 0) held_addr = mem_addr_o;
      else if (mem_addr_o != held_addr) hs_err++;
      wait_cnt++;
      if (wait_cnt >= lat) begin
        mem_valid_i = 1'b1;
        mem_none_i  = no_store(mem_addr_o);
        mem_data_i  = mem_none_i ? 32'hDEAD_BEEF : mem_word(mem_addr_o, gen);
        rd_log[rd_cnt % 8] = mem_addr_o;
        rd_cnt++;
        last_resp_cyc = cyc_cnt;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // issue one fetch and check data, read count, first read address, timing
  task automatic fetch(input logic [31:0] addr, input logic [31:0] exp_data,
                       input int exp_reads, input string req);
    int start, cyc, reads;
    start = rd_cnt;
    @(negedge clk_i);
    fetch_req_i  = 1'b1;
    fetch_addr_i = addr;
    cyc = 0;
    forever begin
      @(negedge clk_i);
      fetch_req_i = 1'b0;
      cyc++;
      if (fetch_valid_o || cyc > 500) break;
    end
    reads = rd_cnt - start;
    check(fetch_valid_o, req, "valid", 32'(fetch_valid_o), 32'h1);
    check(fetch_data_o == exp_data, req, "data", fetch_data_o, exp_data);
    check(reads == exp_reads, req, "reads", 32'(reads), 32'(exp_reads));
    if (exp_reads == 0)
      check(cyc == 1, "R4", "hit latency", 32'(cyc), 32'h1);
    else begin
      check(rd_log[start % 8] == {addr[31:2], 2'b00}, req, "first read addr",
            rd_log[start % 8], {addr[31:2], 2'b00});
      check(cyc_cnt - last_resp_cyc == 1, "R6", "valid after last word",
            32'(cyc_cnt - last_resp_cyc), 32'h1);
    end
  endtask

  task automatic t_reset;
    check(!fetch_valid_o && !mem_req_o, "R7", "reset outputs",
          {30'd0, fetch_valid_o, mem_req_o}, 32'h0);
    fetch(32'h0000_0000, mem_word(32'h0, 0), 4, "R7");
    fetch(32'h0000_0004, mem_word(32'h4, 0), 0, "R1");
    fetch(32'h0000_000C, mem_word(32'hC, 0), 0, "R1");
  endtask

  task automatic t_partial;
    fetch(32'h0000_0208, mem_word(32'h208, 0), 2, "R5");
    check(rd_log[(rd_cnt - 1) % 8] == 32'h20C, "R5", "last read addr",
          rd_log[(rd_cnt - 1) % 8], 32'h20C);
    fetch(32'h0000_020C, mem_word(32'h20C, 0), 0, "R3");
    fetch(32'h0000_0204, mem_word(32'h204, 0), 3, "R3");
    fetch(32'h0000_0200, mem_word(32'h200, 0), 4, "R5");
    fetch(32'h0000_0208, mem_word(32'h208, 0), 0, "R3");
  endtask

  task automatic t_index;
    fetch(32'h0000_1000, mem_word(32'h1000, 0), 4, "R1");
    fetch(32'h0000_0000, mem_word(32'h0, 0), 4, "R1");
    fetch(32'h0000_1000, mem_word(32'h1000, 0), 4, "R1");
  endtask

  task automatic t_bypass;
    fetch(32'h0000_0300, mem_word(32'h300, 0), 4, "R2");
    gen = 1;
    fetch(32'hA000_0300, mem_word(32'hA000_0300, 1), 1, "R2");
    fetch(32'hA000_0000, mem_word(32'hA000_0000, 1), 1, "R2");
    fetch(32'h9FFF_FFFC, mem_word(32'h9FFF_FFFC, 1), 1, "R2");
    fetch(32'h9FFF_FFFC, mem_word(32'h9FFF_FFFC, 1), 0, "R2");
    fetch(32'h0000_0300, mem_word(32'h300, 0), 0, "R2");
  endtask

  task automatic t_enable;
    en_i = 1'b0;
    fetch(32'h0000_0300, mem_word(32'h300, 1), 1, "R9");
    fetch(32'h0000_0300, mem_word(32'h300, 1), 1, "R9");
    en_i = 1'b1;
    fetch(32'h0000_0304, mem_word(32'h304, 0), 0, "R9");
  endtask

  task automatic t_none;
    fetch(32'h1F00_0300, 32'h0, 1, "R8");
    fetch(32'h0000_0308, mem_word(32'h308, 0), 0, "R8");
    fetch(32'hBF00_0010, 32'h0, 1, "R8");
  endtask

  task automatic t_inval;
    @(negedge clk_i);
    inval_i = 1'b1;
    @(negedge clk_i);
    inval_i = 1'b0;
    fetch(32'h0000_0300, mem_word(32'h300, 1), 4, "R7");
    fetch(32'h0000_0000, mem_word(32'h0, 1), 4, "R7");
  endtask

  task automatic t_latency;
    lat = 5;
    fetch(32'h0000_0504, mem_word(32'h504, 1), 3, "R10");
    lat = 1;
    fetch(32'h0000_0608, mem_word(32'h608, 1), 2, "R10");
    lat = 2;
    check(hs_err == 0, "R10", "addr stable while waiting", 32'(hs_err), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_partial();
    t_index();
    t_bypass();
    t_enable();
    t_none();
    t_inval();
    t_latency();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule